// File: doc/BRIEF.md
# Double-Buffered Instruction Prefetch Queue

The block sits between a line-wide memory read port and an instruction decoder. It holds two 16-byte line buffers. It keeps them filled from consecutive aligned line addresses and shows the decoder a three-byte window that starts at the current byte pointer. Each cycle the decoder reports how many of those bytes it used, from zero to three. When the pointer runs past the last byte of a buffer, that buffer is released and its refill is requested at once. Refills do not depend on whether the decoder is moving.

A redirect input, driven by a taken branch or jump, throws away every buffered byte and restarts fetching at the aligned line that holds the target. The pointer is placed at the target's offset inside that line. Each request carries a small stream tag. A line that comes back with a tag from before the latest redirect is discarded, so memory latency may vary freely. After reset the first fetch comes from a reset-vector input.

Top module: `prefetch_queue`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted and in the first cycle after it is released, both buffers are empty (win_count = 0, win_valid = 0). The first request then goes to the reset vector with its low 4 bits cleared, and the byte pointer starts at the low 4 bits of the reset vector.
- R2: mem_req stays high with an unchanged mem_addr until mem_gnt is seen, unless a redirect intervenes. Every requested address has its low 4 bits at zero. At most one request is outstanding: mem_req stays low from a grant until the response arrives.
- R3: Byte k of the window (win_bytes bits 8k+7:8k, k = 0..2) is the instruction byte at pointer + k. win_count gives the number of leading window bytes that are present, capped at 3. win_valid is high exactly when that number is 3.
- R4: A window that runs past byte 15 of the current buffer takes its remaining bytes, in order, from byte 0 upward of the other buffer.
- R5: Line addresses are requested in strictly increasing steps of 16. When consumption moves the pointer past byte 15, that buffer becomes free and is refilled with the next line in sequence.
- R6: Fetching carries on while the decoder consumes nothing, until both buffers hold a line. With both buffers full, no request is made.
- R7: A redirect empties both buffers: win_count is 0 in the next cycle. The next request is for the target address with its low 4 bits cleared, and the window then starts at the target byte.
- R8: A line response whose mem_rtag does not match the tag in force after the latest redirect is discarded and fills no buffer.
- R9: A consume value larger than win_count advances the pointer by win_count only. While win_count is 0, consume has no effect.
- R10: Any number of cycles may pass between grant and response. Line byte i sits at mem_rdata bits 8i+7:8i and is the byte at line address + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | ADDR_W | Byte address fetched first after reset |
| mem_req | output | 1 | Line read request |
| mem_addr | output | ADDR_W | Aligned line address of the request |
| mem_tag | output | TAG_W | Stream tag sent with the request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Single-cycle pulse carrying a line |
| mem_rdata | input | 8*LINE_BYTES | Returned line, byte 0 in the low bits |
| mem_rtag | input | TAG_W | Tag echoed with the returned line |
| redirect | input | 1 | Discard buffered bytes and restart at redirect_addr |
| redirect_addr | input | ADDR_W | New byte address |
| consume | input | 2 | Bytes the decoder takes this cycle |
| win_bytes | output | 24 | Three-byte window, byte 0 in the low bits |
| win_valid | output | 1 | All three window bytes present |
| win_count | output | 2 | Number of leading usable window bytes |

## Verification
The bench aims at windows that cross from one buffer into the other. A wrong boundary split would put bytes from the stale end of the same buffer into the window, and the byte-by-byte comparison against the expected stream would catch it. It places a redirect to an unaligned target while a slow line is still in flight. A design without the tag check would load the old line and show old-stream bytes, or a non-zero count, right after that response. A design that flushed only the pointer would show leftover bytes in the cycle after the redirect. It also holds consume at 3 while the window is empty, so a design that did not clamp would start the new stream at the wrong byte. It stalls the decoder for a long stretch, so a design that fetched only on demand would leave the second buffer empty, and one that ignored the full state would keep requesting.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int TAG_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       reset_vec,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [TAG_W-1:0]        mem_tag,
  input  logic                    mem_gnt,
  input  logic                    mem_rvalid,
  input  logic [8*LINE_BYTES-1:0] mem_rdata,
  input  logic [TAG_W-1:0]        mem_rtag,
  input  logic                    redirect,
  input  logic [ADDR_W-1:0]       redirect_addr,
  input  logic [1:0]              consume,
  output logic [23:0]             win_bytes,
  output logic                    win_valid,
  output logic [1:0]              win_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int CNT_W  = OFF_W + 2;
  localparam int WIN    = 3;

  logic [LINE_W-1:0] line_q [2];
  logic [1:0]        full_q;
  logic              rd_sel, fill_sel, pending;
  logic [OFF_W-1:0]  rd_off;
  logic [ADDR_W-1:0] fetch_addr;
  logic [TAG_W-1:0]  epoch;

  logic [CNT_W-1:0]  avail;
  logic [1:0]        take;
  logic [OFF_W:0]    next_pos;
  logic              fill_ok;

  assign avail = !full_q[rd_sel] ? '0 :
                 CNT_W'(LINE_BYTES) - CNT_W'(rd_off) +
                 (full_q[~rd_sel] ? CNT_W'(LINE_BYTES) : CNT_W'(0));
  assign win_count = (avail >= CNT_W'(WIN)) ? 2'd3 : avail[1:0];
  assign win_valid = (win_count == 2'd3);

  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [OFF_W:0] pos;
    assign pos = {1'b0, rd_off} + (OFF_W+1)'(k);
    assign win_bytes[8*k +: 8] = pos[OFF_W] ? line_q[~rd_sel][8*pos[OFF_W-1:0] +: 8]
                                            : line_q[rd_sel][8*pos[OFF_W-1:0] +: 8];
  end

  assign take     = (consume > win_count) ? win_count : consume;
  assign next_pos = {1'b0, rd_off} + (OFF_W+1)'(take);
  assign fill_ok  = mem_rvalid && pending && (mem_rtag == epoch) && !redirect;

  assign mem_req  = !pending && !full_q[fill_sel] && !redirect;
  assign mem_addr = fetch_addr;
  assign mem_tag  = epoch;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q     <= '0;
      rd_sel     <= 1'b0;
      fill_sel   <= 1'b0;
      pending    <= 1'b0;
      epoch      <= '0;
      rd_off     <= reset_vec[OFF_W-1:0];
      fetch_addr <= {reset_vec[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else if (redirect) begin
      full_q     <= '0;
      rd_sel     <= 1'b0;
      fill_sel   <= 1'b0;
      pending    <= pending && !mem_rvalid;
      epoch      <= epoch + 1'b1;
      rd_off     <= redirect_addr[OFF_W-1:0];
      fetch_addr <= {redirect_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else begin
      if (mem_req && mem_gnt) begin
        pending    <= 1'b1;
        fetch_addr <= fetch_addr + ADDR_W'(LINE_BYTES);
      end else if (mem_rvalid && pending) begin
        pending <= 1'b0;
      end
      if (fill_ok) begin
        line_q[fill_sel] <= mem_rdata;
        full_q[fill_sel] <= 1'b1;
        fill_sel         <= ~fill_sel;
      end
      if (next_pos[OFF_W]) begin
        full_q[rd_sel] <= 1'b0;
        rd_sel         <= ~rd_sel;
      end
      rd_off <= next_pos[OFF_W-1:0];
    end
  end

  a_r2_hold_req: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> redirect || (mem_req && $stable(mem_addr)));

  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[OFF_W-1:0] == '0);

  a_r2_single: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt |=> !mem_req);

  a_r6_full_idle: assert property (@(posedge clk) disable iff (rst)
    (&full_q) |-> !mem_req);

  a_r7_flush: assert property (@(posedge clk) disable iff (rst)
    redirect |=> win_count == 2'd0 && !win_valid);

  a_r8_stale: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid && mem_rtag != epoch |=> (full_q & ~$past(full_q)) == 2'b00);
endmodule

// File: tb/prefetch_queue_bench.sv
`timescale 1ns/1ps
module prefetch_queue_bench;
  localparam int ADDR_W = 32;
  localparam int LB     = 16;
  localparam int TAG_W  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] reset_vec;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [TAG_W-1:0]  mem_tag;
  logic              mem_gnt;
  logic              mem_rvalid;
  logic [8*LB-1:0]   mem_rdata;
  logic [TAG_W-1:0]  mem_rtag;
  logic              redirect;
  logic [ADDR_W-1:0] redirect_addr;
  logic [1:0]        consume;
  logic [23:0]       win_bytes;
  logic              win_valid;
  logic [1:0]        win_count;

  always #2.5 clk = ~clk;

  prefetch_queue #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .TAG_W(TAG_W)) u_prefetch_queue (
    .clk(clk), .rst(rst), .reset_vec(reset_vec),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_tag(mem_tag), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rtag(mem_rtag),
    .redirect(redirect), .redirect_addr(redirect_addr), .consume(consume),
    .win_bytes(win_bytes), .win_valid(win_valid), .win_count(win_count));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] fb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  logic [7:0]  exp_q[$];
  logic [31:0] exp_ptr;
  logic [31:0] exp_fetch;
  bit          in_flight = 0;
  bit          slow = 0;
  int          nreq = 0;
  int          dmode = 0;

  task automatic push_stream(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(fb(a + 32'(i)));
  endtask

  // memory model: variable grant delay and latency
  initial begin
    logic [31:0] a;
    logic [TAG_W-1:0] t;
    int gd, lat;
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; mem_rtag = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (!rst && mem_req) begin
        a = mem_addr;
        gd = nreq % 3;
        lat = slow ? 6 : 1 + (nreq % 4);
        nreq++;
        for (int i = 0; i < gd; i++) begin
          @(negedge clk);
          chk(mem_req && mem_addr == a, "R2", "request held", mem_addr, a);
        end
        chk(mem_addr == exp_fetch, "R5", "line address", mem_addr, exp_fetch);
        a = mem_addr;
        t = mem_tag;
        mem_gnt = 1;
        @(negedge clk);
        mem_gnt = 0;
        exp_fetch = exp_fetch + 32'(LB);
        in_flight = 1;
        for (int i = 0; i < lat - 1; i++) begin
          chk(!mem_req, "R2", "single outstanding", mem_req, 0);
          @(negedge clk);
        end
        for (int i = 0; i < LB; i++) mem_rdata[8*i +: 8] = fb(a + 32'(i));
        mem_rtag = t;
        mem_rvalid = 1;
        in_flight = 0;
      end
    end
  end

  // decoder driver and scoreboard monitor
  initial begin
    int pat [6] = '{1, 2, 3, 0, 3, 2};
    int pi = 0;
    consume = 0;
    forever begin
      @(negedge clk);
      if (rst || dmode == 0) consume = 0;
      else if (dmode == 1) consume = 2'd3;
      else begin
        int n, c;
        n = win_count;
        chk(win_valid == (n == 3), "R3", "valid vs count", win_valid, n == 3);
        c = pat[pi % 6];
        pi++;
        if (c > n) c = n;
        if (c > exp_q.size()) c = exp_q.size();
        for (int k = 0; k < c; k++) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(win_bytes[8*k +: 8] == e, (32'(exp_ptr[3:0]) + k > 15) ? "R4" : "R3",
              "window byte", win_bytes[8*k +: 8], e);
        end
        exp_ptr = exp_ptr + 32'(c);
        consume = 2'(c);
      end
    end
  end

  task automatic do_redirect(input logic [31:0] tgt);
    int n;
    bit seen;
    dmode = 1;
    slow = 1;
    while (!in_flight) begin @(posedge clk); #1; end
    redirect = 1;
    redirect_addr = tgt;
    exp_q.delete();
    push_stream(tgt, 1000);
    exp_ptr = tgt;
    exp_fetch = {tgt[31:4], 4'h0};
    @(posedge clk); #1;
    redirect = 0;
    chk(win_count == 0 && !win_valid, "R7", "flushed window", win_count, 0);
    n = 0;
    seen = 0;
    while (win_count == 0 && n < 100) begin
      if (mem_rvalid && !seen) begin
        seen = 1;
        chk(win_count == 0, "R8", "stale line dropped", win_count, 0);
      end
      @(posedge clk); #1;
      n++;
    end
    chk(win_bytes[7:0] == fb(tgt), "R9", "first byte after over-consume", win_bytes[7:0], fb(tgt));
    chk(win_bytes[7:0] == fb(tgt), "R7", "window starts at target", win_bytes[7:0], fb(tgt));
    slow = 0;
    dmode = 2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    reset_vec = 32'h0000_1007;
    redirect = 0;
    redirect_addr = '0;
    exp_fetch = 32'h0000_1000;
    exp_ptr = 32'h0000_1007;
    push_stream(32'h0000_1007, 1000);
    repeat (4) @(posedge clk);
    #1;
    chk(win_count == 0 && !win_valid, "R1", "empty during reset", win_count, 0);
    rst = 0;
    #1;
    chk(win_count == 0, "R1", "empty after reset", win_count, 0);
    chk(mem_req == 1, "R1", "first request", mem_req, 1);
    chk(mem_addr == 32'h0000_1000, "R1", "first address", mem_addr, 32'h1000);
    repeat (40) @(posedge clk);
    #1;
    chk(!mem_req, "R6", "no request with both full", mem_req, 0);
    chk(win_count == 3, "R6", "window full while stalled", win_count, 3);
    chk(exp_fetch == 32'h0000_1020, "R6", "two lines fetched", exp_fetch, 32'h1020);
    chk(win_bytes[7:0] == fb(32'h1007), "R1", "pointer at reset offset", win_bytes[7:0], fb(32'h1007));
    dmode = 2;
    repeat (300) @(posedge clk);
    #1;
    chk(exp_fetch > 32'h0000_1040, "R10", "lines streamed under varied latency", exp_fetch, 32'h1040);
    do_redirect(32'h0000_200E);
    repeat (300) @(posedge clk);
    #1;
    do_redirect(32'h0000_3005);
    repeat (200) @(posedge clk);
    #1;
    dmode = 0;
    chk(exp_ptr > 32'h0000_3005, "R5", "stream advanced after redirect", exp_ptr, 32'h3006);
    report();
  end
endmodule